// File: doc/BRIEF.md
# SHA-256 Message Schedule Generator

This block turns one 512-bit message block into the 64-word schedule that a SHA-256 compression engine consumes. It delivers one word per clock, in the same order as the engine's rounds. A start strobe captures the block. From the next cycle the block drives a valid flag, the current round index and the schedule word for that round.

Only sixteen words are stored. They sit in a sliding window shift register. The first sixteen rounds simply read out the captured input words. Each later word comes from four older entries in the window, combined through the two small sigma mixing functions. Every cycle the new word enters at the young end and the oldest word leaves.

The block runs in lockstep with the round engine. A start strobe that arrives during the final round chains the next block in with no idle cycle between the two blocks.

Top module: `sha256_msg_sched`

## Requirements
- R1: While reset is asserted and after it is released with no start, `w_valid_o` is 0 and `round_o` is 0.
- R2: A start sampled while the block is idle sets `w_valid_o` to 1 and `round_o` to 0 in the following cycle.
- R3: For rounds 0 to 15, `w_o` equals input word u, where word u is `block_i[511-32u -: 32]`. Word 0 is therefore the most significant 32 bits.
- R4: For rounds 16 to 63, `w_o` equals s1(W[u-2]) + W[u-7] + s0(W[u-15]) + W[u-16], taken modulo 2^32. Here s0(x) = rotr7(x) ^ rotr18(x) ^ (x>>3) and s1(x) = rotr17(x) ^ rotr19(x) ^ (x>>10).
- R5: After a start, `w_valid_o` stays high for exactly 64 consecutive cycles, and `round_o` steps by one from 0 to 63.
- R6: If no start arrives during round 63, `w_valid_o` falls in the next cycle and stays low until a start.
- R7: A start asserted during rounds 0 to 62 is ignored. The round index and the schedule words continue unchanged.
- R8: A start asserted during round 63 is accepted. The next cycle shows round 0 of the new block with `w_valid_o` still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, captures `block_i` when accepted |
| block_i | input | 512 | Message block, word 0 in the top bits |
| w_o | output | 32 | Schedule word for the current round |
| w_valid_o | output | 1 | High while a schedule word is being delivered |
| round_o | output | 6 | Round index of `w_o` |

## Verification
The hardest cases to reach are the two kinds of start that arrive while a block is still running. A strobe during a middle round must leave the window untouched. A strobe landing exactly in round 63 must reload the window in the same edge that would otherwise drop valid. The stimulus raises start at round 20 with a different block and then checks every remaining word against the first block. In another run it raises start only during round 63 and checks that round 0 of the second block follows immediately. Each of the varied blocks has all 64 words compared with a schedule computed arithmetically in the bench.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int unsigned WORD_W = 32;
  // recursion distances, in words back from the word being produced
  localparam int unsigned DIST_S1 = 2;
  localparam int unsigned DIST_MID = 7;
  localparam int unsigned DIST_S0 = 15;
  localparam int unsigned DIST_OLD = 16;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t rotr(input word_t x, input int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t small_sig0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t small_sig1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction
endpackage

// File: rtl/sched_mix.sv
module sched_mix
  import sched_pkg::*;
(
  input  word_t tap_s1_i,
  input  word_t tap_mid_i,
  input  word_t tap_s0_i,
  input  word_t tap_old_i,
  output word_t nxt_o
);
  word_t sum_a, sum_b;

  always_comb begin
    sum_a = small_sig1(tap_s1_i) + tap_mid_i;
    sum_b = small_sig0(tap_s0_i) + tap_old_i;
    nxt_o = sum_a + sum_b;
  end
endmodule

// File: rtl/sched_seq.sv
module sched_seq #(
  parameter int unsigned ROUNDS = 64,
  localparam int unsigned RIDX_W = $clog2(ROUNDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              load_o,
  output logic              adv_o,
  output logic              vld_o,
  output logic [RIDX_W-1:0] round_o
);
  localparam logic [RIDX_W-1:0] LAST_RND = RIDX_W'(ROUNDS - 1);

  logic              vld_q, vld_d;
  logic [RIDX_W-1:0] rnd_q, rnd_d;
  logic              last_rnd;

  always_comb begin
    last_rnd = vld_q && (rnd_q == LAST_RND);
    load_o   = start_i && (!vld_q || last_rnd);
    adv_o    = vld_q && !load_o;
    vld_d    = vld_q;
    rnd_d    = rnd_q;
    if (load_o) begin
      vld_d = 1'b1;
      rnd_d = '0;
    end else if (last_rnd) begin
      vld_d = 1'b0;
    end else if (vld_q) begin
      rnd_d = rnd_q + RIDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      rnd_q <= '0;
    end else begin
      vld_q <= vld_d;
      rnd_q <= rnd_d;
    end
  end

  assign vld_o   = vld_q;
  assign round_o = rnd_q;

  // R2
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !vld_o) |=> (vld_o && round_o == '0));
  // R5
  round_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && round_o != LAST_RND) |=> (vld_o && round_o == $past(round_o) + RIDX_W'(1)));
  // R6
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && round_o == LAST_RND && !start_i) |=> !vld_o);
  // R8
  chain_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && round_o == LAST_RND && start_i) |=> (vld_o && round_o == '0));
endmodule

// File: rtl/sched_window.sv
module sched_window
  import sched_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned BLK_W = DEPTH * WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [BLK_W-1:0] blk_i,
  input  word_t            nxt_i,
  output word_t            head_o,
  output word_t            tap_s1_o,
  output word_t            tap_mid_o,
  output word_t            tap_s0_o,
  output word_t            tap_old_o
);
  word_t win_q [DEPTH];
  word_t win_d [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    word_t shift_in;
    if (i == DEPTH - 1) begin : g_young
      assign shift_in = nxt_i;
    end else begin : g_mid
      assign shift_in = win_q[i+1];
    end

    always_comb begin
      win_d[i] = win_q[i];
      if (load_i)
        win_d[i] = blk_i[BLK_W-1-WORD_W*i -: WORD_W];
      else if (adv_i)
        win_d[i] = shift_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_q[i] <= '0;
      else        win_q[i] <= win_d[i];
    end
  end

  assign head_o    = win_q[0];
  assign tap_old_o = win_q[DEPTH - DIST_OLD];
  assign tap_s0_o  = win_q[DEPTH - DIST_S0];
  assign tap_mid_o = win_q[DEPTH - DIST_MID];
  assign tap_s1_o  = win_q[DEPTH - DIST_S1];

  // R3
  load_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (head_o == $past(blk_i[BLK_W-1 -: WORD_W])));
  // R4
  shift_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> (head_o == $past(win_q[1])));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> $stable(head_o));
endmodule

// File: rtl/sha256_msg_sched.sv
module sha256_msg_sched
  import sched_pkg::*;
#(
  parameter int unsigned WIN_DEPTH = 16,
  parameter int unsigned ROUNDS = 64,
  localparam int unsigned BLK_W = WIN_DEPTH * WORD_W,
  localparam int unsigned RIDX_W = $clog2(ROUNDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BLK_W-1:0]  block_i,
  output logic [WORD_W-1:0] w_o,
  output logic              w_valid_o,
  output logic [RIDX_W-1:0] round_o
);
  logic  load, adv;
  word_t t_s1, t_mid, t_s0, t_old, nxt, head;

  sched_seq #(.ROUNDS(ROUNDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .load_o(load), .adv_o(adv), .vld_o(w_valid_o), .round_o(round_o)
  );

  sched_window #(.DEPTH(WIN_DEPTH)) u_win (
    .clk(clk), .rst_n(rst_n), .load_i(load), .adv_i(adv),
    .blk_i(block_i), .nxt_i(nxt), .head_o(head),
    .tap_s1_o(t_s1), .tap_mid_o(t_mid), .tap_s0_o(t_s0), .tap_old_o(t_old)
  );

  sched_mix u_mix (
    .tap_s1_i(t_s1), .tap_mid_i(t_mid), .tap_s0_i(t_s0), .tap_old_i(t_old),
    .nxt_o(nxt)
  );

  assign w_o = head;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!w_valid_o && round_o == '0));
  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_valid_o && round_o != RIDX_W'(ROUNDS - 1) && start_i) |=> (round_o != '0));
endmodule

// File: tb/tb_sha256_msg_sched.sv
module tb_sha256_msg_sched;
  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic [511:0] block_i;
  logic [31:0]  w_o;
  logic         w_valid_o;
  logic [5:0]   round_o;

  int n_chk;
  int n_fail;
  bit done;

  sha256_msg_sched dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .block_i(block_i),
    .w_o(w_o), .w_valid_o(w_valid_o), .round_o(round_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    logic [63:0] d;
    d = {x, x} >> n;
    return d[31:0];
  endfunction

  function automatic logic [31:0] ref_s0(input logic [31:0] x);
    return rr(x, 7) ^ rr(x, 18) ^ {3'b0, x[31:3]};
  endfunction

  function automatic logic [31:0] ref_s1(input logic [31:0] x);
    return rr(x, 17) ^ rr(x, 19) ^ {10'b0, x[31:10]};
  endfunction

  logic [31:0] expw [64];

  task automatic build_ref(input logic [511:0] b);
    for (int u = 0; u < 16; u++) expw[u] = b[511-32*u -: 32];
    for (int u = 16; u < 64; u++)
      expw[u] = 32'(64'(ref_s1(expw[u-2])) + 64'(expw[u-7]) +
                    64'(ref_s0(expw[u-15])) + 64'(expw[u-16]));
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // checks one 64-round run; optional mid-run poke and round-63 chain start
  task automatic run_chk(input logic [511:0] b, input int poke_r, input logic [511:0] poke_b,
                         input bit chain, input logic [511:0] nb);
    build_ref(b);
    for (int r = 0; r < 64; r++) begin
      chk(w_valid_o == 1'b1, "R5 valid", 32'(w_valid_o), 32'd1);
      chk(round_o == 6'(r), "R5 round", 32'(round_o), 32'(r));
      chk(w_o == expw[r], (r < 16) ? "R3 word" : "R4 word", w_o, expw[r]);
      start_i = 1'b0;
      if (r == poke_r) begin           // R7 stimulus
        start_i = 1'b1;
        block_i = poke_b;
      end else if (chain && r == 63) begin  // R8 stimulus
        start_i = 1'b1;
        block_i = nb;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    if (!chain) begin
      for (int k = 0; k < 3; k++) begin
        chk(w_valid_o == 1'b0, "R6 idle", 32'(w_valid_o), 32'd0);
        @(negedge clk);
      end
    end
  endtask

  task automatic kick(input logic [511:0] b);
    start_i = 1'b1;
    block_i = b;
    @(negedge clk);
    start_i = 1'b0;
    chk(w_valid_o && round_o == 6'd0, "R2 start", {25'b0, w_valid_o, round_o}, 32'h40);
  endtask

  initial begin
    logic [511:0] pat;
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; start_i = 1'b0; block_i = '0;
    repeat (3) @(negedge clk);
    chk(!w_valid_o && round_o == 6'd0, "R1 in reset", {25'b0, w_valid_o, round_o}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!w_valid_o && round_o == 6'd0, "R1 after release", {25'b0, w_valid_o, round_o}, 32'd0);

    // padded three-byte message
    pat = '0;
    pat[511:480] = 32'h61626380;
    pat[31:0] = 32'h00000018;
    kick(pat); run_chk(pat, -1, '0, 1'b0, '0);
    // all zeros, all ones (carry wrap)
    kick('0); run_chk('0, -1, '0, 1'b0, '0);
    kick({512{1'b1}}); run_chk({512{1'b1}}, -1, '0, 1'b0, '0);
    // counting words and walking ones
    for (int i = 0; i < 16; i++) pat[511-32*i -: 32] = 32'(i + 1);
    kick(pat); run_chk(pat, -1, '0, 1'b0, '0);
    for (int i = 0; i < 16; i++) pat[511-32*i -: 32] = 32'h1 << (i * 2);
    kick(pat); run_chk(pat, 20, {512{1'b1}}, 1'b0, '0);  // R7 poke at round 20
    // pseudo-random words, chained into a second block at round 63
    begin
      logic [31:0] s;
      logic [511:0] p2;
      s = 32'h1234abcd;
      for (int i = 0; i < 16; i++) begin
        s = s * 32'd1664525 + 32'd1013904223;
        pat[511-32*i -: 32] = s;
      end
      for (int i = 0; i < 16; i++) begin
        s = s * 32'd1664525 + 32'd1013904223;
        p2[511-32*i -: 32] = s ^ 32'h5a5a0f0f;
      end
      kick(pat);
      run_chk(pat, -1, '0, 1'b1, p2);
      chk(w_valid_o && round_o == 6'd0, "R8 chained", {25'b0, w_valid_o, round_o}, 32'h40);
      run_chk(p2, -1, '0, 1'b0, '0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule